// File: doc/BRIEF.md
# Cascaded Two-Level Priority Interrupt Controller

This block gathers up to 64 level-sensitive interrupt requests into one processor interrupt. The requests are arranged as eight groups of eight lines. Each group is served by a slave unit, which resolves priority among its lines and raises one request of its own. The eight slave requests feed a master unit, which resolves priority among the slaves and drives the single processor interrupt line. Both levels use fixed priority: index 0 wins and index 7 loses.

Service takes a two-strobe acknowledge handshake. On the first acknowledge strobe, every unit captures its request inputs and holds them. The master then publishes on a 3-bit cascade bus the index of the winning slave. Each slave compares that bus with its own index, which acts as its chip select. On the second strobe, only the selected slave loads its vector. The vector is the slave's fixed 5-bit base (vector base origin plus slave index) in the upper bits, followed by the 3-bit index of its winning line. One cycle later the captured requests are released and the controller is idle again.

The master sequencer has three states. IDLE goes to CASCADE on an acknowledge strobe (transition FREEZE). CASCADE goes to VECTOR on an acknowledge strobe (transition LOAD). VECTOR always goes back to IDLE after one cycle (transition RELEASE). The slaves follow these transitions through the freeze, load and release pulses.

Top module: `cic_cascade`

## Requirements
- R1: After reset, cpu_int is 0 with no requests, and cas_valid, cas_addr, vec_valid and vec_data are all 0.
- R2: In IDLE, cpu_int is 1 in the same cycle exactly when any bit of irq_req is 1. irq_req bit 8*s+l is line l of slave s.
- R3: The first acknowledge strobe captures irq_req. Changes on irq_req after that edge do not alter cas_addr or the vector of the running sequence.
- R4: From the cycle after the first strobe until the sequence ends, cas_valid is 1. cas_addr holds the lowest-numbered slave that has any captured line set.
- R5: Inside the selected slave, the lowest-numbered captured line wins.
- R6: vec_data = {base, line}: the upper 5 bits are (VEC_BASE_ORIGIN + slave) mod 32 and the lower 3 bits are the winning line. Only the slave addressed by the cascade bus supplies it.
- R7: vec_valid is 1 for exactly the one cycle that follows the second acknowledge strobe.
- R8: If no line is set when requests are captured, the result is slave 7, line 7 (vector {base of slave 7, 3'd7}).
- R9: Whenever cas_valid is 0, cas_addr is 0. Whenever vec_valid is 0, vec_data is 0.
- R10: After the vector cycle, the controller returns to IDLE. Captured requests are released and cpu_int again follows the live requests. A strobe that arrives during the vector cycle is ignored.
- R11: cpu_int is 0 throughout the acknowledge sequence (CASCADE and VECTOR states).
- R12: A request that drops before the first strobe is not serviced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 64 | Level requests; bit 8*s+l is line l of slave s |
| ack_strobe | input | 1 | One-cycle interrupt-acknowledge strobe from the processor |
| cpu_int | output | 1 | Interrupt request to the processor |
| cas_valid | output | 1 | Cascade address is being driven |
| cas_addr | output | 3 | Index of the selected slave |
| vec_valid | output | 1 | Vector is being driven |
| vec_data | output | 8 | Interrupt vector from the selected slave |

## Verification
cpu_int is combinational from irq_req and is due in the same cycle. The cascade address appears one cycle after the clock edge that takes the first strobe. The vector appears one cycle after the edge that takes the second strobe. Everything clears one edge after that. The bench changes inputs and samples outputs on the falling edge. It checks registered results at the falling edge that follows the edge that produced them. It checks cpu_int one time unit after driving irq_req.

// File: rtl/cic_pkg.sv
package cic_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CASCADE = 2'd1,
        ST_VECTOR  = 2'd2
    } ack_state_t;
endpackage

// File: rtl/cic_prio_enc.sv
// Fixed-priority encoder: lowest set index wins, all-zero input yields N-1.
module cic_prio_enc #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = IW'(N - 1);
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/cic_slave.sv
// One second-level unit: captures its lines on freeze, supplies a vector when chip-selected.
module cic_slave #(
    parameter int LINES   = 8,
    parameter int NSLOTS  = 8,
    parameter int SLOT    = 0,
    parameter int BASE_W  = 5,
    parameter int BASE0   = 4,
    parameter int LW      = $clog2(LINES),
    parameter int SW      = $clog2(NSLOTS),
    parameter int VW      = BASE_W + LW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] req,
    input  logic             freeze,
    input  logic             load,
    input  logic             release_i,
    input  logic [SW-1:0]    cas_addr,
    output logic             int_out,
    output logic             vec_valid,
    output logic [VW-1:0]    vec_data
);
    localparam logic [BASE_W-1:0] MY_BASE = BASE_W'(BASE0 + SLOT);

    logic [LINES-1:0] frz_q;
    logic             frozen_q;
    logic [LINES-1:0] eff_req;
    logic             any_req;
    logic [LW-1:0]    win_line;
    logic             chip_sel;
    logic             vec_v_q;
    logic [VW-1:0]    vec_q;

    assign eff_req  = frozen_q ? frz_q : req;
    assign chip_sel = (cas_addr == SW'(SLOT));

    cic_prio_enc #(.N(LINES), .IW(LW)) u_enc (
        .req (eff_req),
        .any (any_req),
        .idx (win_line)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frz_q    <= '0;
            frozen_q <= 1'b0;
            vec_v_q  <= 1'b0;
            vec_q    <= '0;
        end else if (release_i) begin
            frz_q    <= '0;
            frozen_q <= 1'b0;
            vec_v_q  <= 1'b0;
            vec_q    <= '0;
        end else begin
            if (freeze) begin
                frz_q    <= req;
                frozen_q <= 1'b1;
            end
            if (load && chip_sel) begin
                vec_q   <= {MY_BASE, win_line};
                vec_v_q <= 1'b1;
            end
        end
    end

    assign int_out   = any_req;
    assign vec_valid = vec_v_q;
    assign vec_data  = vec_q;

    // R3: captured lines stay fixed until release
    assert_frozen_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen_q && !release_i) |=> $stable(frz_q));

    // R6: a vector is only loaded by the slave the cascade bus addressed
    assert_chip_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_v_q) |-> ($past(cas_addr) == SW'(SLOT)));
endmodule

// File: rtl/cic_master.sv
// First-level unit and acknowledge sequencer.
module cic_master #(
    parameter int NSLOTS = 8,
    parameter int SW     = $clog2(NSLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSLOTS-1:0] slave_int,
    input  logic              ack,
    output logic              cpu_int,
    output logic              cas_valid,
    output logic [SW-1:0]     cas_addr,
    output logic              freeze,
    output logic              load,
    output logic              release_o
);
    import cic_pkg::*;

    ack_state_t    state_q, state_d;
    logic          any_slave;
    logic [SW-1:0] win_slave;
    logic [SW-1:0] cas_q;
    logic          cas_v_q;

    cic_prio_enc #(.N(NSLOTS), .IW(SW)) u_enc (
        .req (slave_int),
        .any (any_slave),
        .idx (win_slave)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (ack) state_d = ST_CASCADE;
            ST_CASCADE: if (ack) state_d = ST_VECTOR;
            ST_VECTOR:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cas_q   <= '0;
            cas_v_q <= 1'b0;
        end else if (release_o) begin
            cas_q   <= '0;
            cas_v_q <= 1'b0;
        end else if (freeze) begin
            cas_q   <= win_slave;
            cas_v_q <= 1'b1;
        end
    end

    always_comb begin
        freeze    = 1'b0;
        load      = 1'b0;
        release_o = 1'b0;
        cpu_int   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                freeze  = ack;
                cpu_int = any_slave;
            end
            ST_CASCADE: load      = ack;
            ST_VECTOR:  release_o = 1'b1;
            default:    ;
        endcase
        cas_valid = cas_v_q;
        cas_addr  = cas_v_q ? cas_q : '0;
    end

    // R4: the cascade address is published for the whole sequence
    assert_cas_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> cas_v_q);

    // R10: the vector state lasts one cycle and releases the cascade bus
    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_VECTOR) |=> (state_q == ST_IDLE && !cas_v_q));

    // R4: the cascade address does not move while published
    assert_cas_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CASCADE) |=> $stable(cas_q));
endmodule

// File: rtl/cic_cascade.sv
module cic_cascade #(
    parameter int NUM_SLAVES      = 8,
    parameter int LINES           = 8,
    parameter int BASE_W          = 5,
    parameter int VEC_BASE_ORIGIN = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_SLAVES*LINES-1:0]        irq_req,
    input  logic                               ack_strobe,
    output logic                               cpu_int,
    output logic                               cas_valid,
    output logic [$clog2(NUM_SLAVES)-1:0]      cas_addr,
    output logic                               vec_valid,
    output logic [BASE_W+$clog2(LINES)-1:0]    vec_data
);
    localparam int SW = $clog2(NUM_SLAVES);
    localparam int LW = $clog2(LINES);
    localparam int VW = BASE_W + LW;

    logic [NUM_SLAVES-1:0] slave_int;
    logic [NUM_SLAVES-1:0] slave_vv;
    logic [VW-1:0]         slave_vec [NUM_SLAVES];
    logic                  freeze, load, release_p;

    cic_master #(.NSLOTS(NUM_SLAVES), .SW(SW)) u_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .slave_int (slave_int),
        .ack       (ack_strobe),
        .cpu_int   (cpu_int),
        .cas_valid (cas_valid),
        .cas_addr  (cas_addr),
        .freeze    (freeze),
        .load      (load),
        .release_o (release_p)
    );

    for (genvar s = 0; s < NUM_SLAVES; s++) begin : g_slave
        cic_slave #(
            .LINES  (LINES),
            .NSLOTS (NUM_SLAVES),
            .SLOT   (s),
            .BASE_W (BASE_W),
            .BASE0  (VEC_BASE_ORIGIN),
            .LW     (LW),
            .SW     (SW),
            .VW     (VW)
        ) u_slave (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (irq_req[s*LINES +: LINES]),
            .freeze    (freeze),
            .load      (load),
            .release_i (release_p),
            .cas_addr  (cas_addr),
            .int_out   (slave_int[s]),
            .vec_valid (slave_vv[s]),
            .vec_data  (slave_vec[s])
        );
    end

    always_comb begin
        vec_data = '0;
        for (int s = 0; s < NUM_SLAVES; s++) vec_data |= slave_vec[s];
    end
    assign vec_valid = |slave_vv;

    // R6: at most one slave drives the vector
    assert_single_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slave_vv));

    // R9: vector bus quiet when not valid
    assert_vec_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> (vec_data == '0));

    // R7: a vector only appears while a cascade address is published
    assert_vec_in_seq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> cas_valid);

    // R11: no processor interrupt while a vector is out
    assert_quiet_int_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_valid || vec_valid) |-> !cpu_int);
endmodule

// File: tb/cic_cascade_tb.sv
`timescale 1ns/1ps
module cic_cascade_tb;
    localparam int BASE0 = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_req = '0;
    logic        ack_strobe = 1'b0;
    logic        cpu_int, cas_valid, vec_valid;
    logic [2:0]  cas_addr;
    logic [7:0]  vec_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cic_cascade u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_req    (irq_req),
        .ack_strobe (ack_strobe),
        .cpu_int    (cpu_int),
        .cas_valid  (cas_valid),
        .cas_addr   (cas_addr),
        .vec_valid  (vec_valid),
        .vec_data   (vec_data)
    );

    function automatic logic [2:0] exp_slave(input logic [63:0] r);
        for (int s = 0; s < 8; s++) if (r[s*8 +: 8] != 0) return 3'(s);
        return 3'd7;
    endfunction

    function automatic logic [7:0] exp_vec(input logic [63:0] r);
        logic [2:0] s = exp_slave(r);
        logic [7:0] b = r[s*8 +: 8];
        logic [2:0] l = 3'd7;
        for (int i = 7; i >= 0; i--) if (b[i]) l = 3'(i);
        return {5'(BASE0 + int'(s)), l};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Full acknowledge sequence; irq changes to 'later' after the first strobe.
    task automatic run_seq(input logic [63:0] pre, input logic [63:0] later, input bit hold_ack);
        logic [63:0] frz = pre;
        @(negedge clk);
        irq_req = pre;
        #1;
        check("R2 cpu_int idle", cpu_int, |pre);
        ack_strobe = 1'b1;
        @(negedge clk);
        ack_strobe = 1'b0;
        check("R4 cas_valid", cas_valid, 1);
        check("R4 cas_addr", cas_addr, exp_slave(frz));
        check("R11 cpu_int in cascade", cpu_int, 0);
        check("R7 no early vector", vec_valid, 0);
        irq_req = later;
        #1;
        check("R11 cpu_int after change", cpu_int, 0);
        @(negedge clk);
        check("R3 cas_addr frozen", cas_addr, exp_slave(frz));
        ack_strobe = 1'b1;
        @(negedge clk);
        ack_strobe = hold_ack;
        check("R7 vec_valid", vec_valid, 1);
        check("R6 R5 R3 vec_data", vec_data, exp_vec(frz));
        check("R4 cas during vector", cas_addr, exp_slave(frz));
        @(negedge clk);
        ack_strobe = 1'b0;
        check("R7 vec_valid one cycle", vec_valid, 0);
        check("R9 vec_data zero", vec_data, 0);
        check("R10 cas released", cas_valid, 0);
        check("R9 cas_addr zero", cas_addr, 0);
        check("R10 cpu_int live", cpu_int, |later);
        @(negedge clk);
        check("R10 stays idle", cas_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] a, b;
        int unused_seed;
        unused_seed = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        check("R1 cpu_int reset", cpu_int, 0);
        check("R1 cas_valid reset", cas_valid, 0);
        check("R1 vec_valid reset", vec_valid, 0);
        check("R1 vec_data reset", vec_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 cas_addr after reset", cas_addr, 0);

        // R8: nothing pending -> slave 7 line 7
        run_seq(64'h0, 64'h0, 0);
        // R4 R5: slave 3 lines 2,5 beat slave 5 line 0
        run_seq(64'h0000_0100_2400_0000, 64'h0, 0);
        // only the lowest-priority source
        run_seq(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 0);
        // R3: requests change after capture
        run_seq(64'h0000_0000_0080_0000, 64'h0000_0000_0000_0001, 0);
        // R10: strobe held during vector cycle is ignored
        run_seq(64'h0000_0000_0000_0040, 64'h0, 1);

        // R12: a pulse that drops before the strobe is not serviced
        @(negedge clk);
        irq_req = 64'h0000_0000_0000_0001;
        #1;
        check("R2 pulse raises cpu_int", cpu_int, 1);
        @(negedge clk);
        irq_req = 64'h0;
        #1;
        check("R12 cpu_int dropped", cpu_int, 0);
        run_seq(64'h0, 64'h0, 0);
        check("R12 dropped request not serviced", vec_data, 0);

        for (int k = 0; k < 60; k++) begin
            a = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            if (k % 4 == 0) a = a & 64'hFF00_0000_0000_0000;
            if (k % 7 == 0) a = 64'h0;
            b = {$urandom, $urandom};
            run_seq(a, b, k[0]);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule